// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This block is a real-time-clock core that keeps time as a count of seconds. A pulse on `tick` (one per second, generated elsewhere) advances an up-counter by one and a paired down-counter by one in the other direction. Software keeps the down-counter equal to the bitwise complement of the up-counter. Two match registers are compared against the up-counter. Each equality sets a sticky status latch. The latches feed an interrupt line, and they can also raise a separate power-on-switch output that wakes the rest of the system.

Software reaches the block through a simple synchronous register bus with 32-bit data and byte offsets. The up-counter sits at 0x00 and the down-counter at 0x04. The first match value is at 0x08 and the second at 0x0C. Control is at 0x10, status at 0x14, and the setup key at 0x18.

To set the time, software sets the freeze bit in control, writes both counters, and clears the freeze bit. The key register holds any value written to it, so software can record there that first-time setup is complete. A software-reset bit in control clears the counters and status latches but leaves the configuration in place.

Top module: `rtc_sec_core`

## Requirements
- R1: After `rst_n` is low at a clock edge, the registers read as follows. Up-counter 0, down-counter 0xFFFFFFFF, both match registers 0xFFFFFFFF, and control, status and key 0. `irq` and `onsw_out` are low.
- R2: At each clock edge with `tick` high, freeze (control bit 6) low and soft reset (control bit 4) low, the up-counter increases by 1 and the down-counter decreases by 1. Without a tick, both counters hold.
- R3: The counters wrap modulo 2^32. The up-counter goes from 0xFFFFFFFF to 0, and the down-counter goes from 0 to 0xFFFFFFFF.
- R4: While control bit 6 is set, ticks are ignored. A bus write to offset 0x00 or 0x04 loads that counter at the next edge.
- R5: A bus write to offset 0x00 or 0x04 while control bit 6 is clear has no effect on either counter.
- R6: Status bit k (k = 0 for the first match, k = 1 for the second) is set at the edge after a cycle in which the up-counter equals match register k. This happens whether or not the interrupt for that match is enabled. While the equality holds, a clear request does not remove the bit.
- R7: Writing offset 0x14 clears each status bit whose write-data bit is 1 (bits 0, 1 and 2) and leaves bits written with 0 unchanged.
- R8: `irq` = (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1).
- R9: Status bit 2 is set at the edge after a cycle in which an equality on match k coincides with control bit 2+k. `onsw_out` = status bit 2 OR control bit 7.
- R10: While control bit 4 is set, both counters are held at 0, all status bits are held at 0, and counter writes and ticks are ignored. The control, match and key registers keep their values.
- R11: The key register stores and returns any 32-bit value. Control reads back only bits 0–4, 6 and 7 of what was written (write mask 0xDF). Status reads back bits 2:0 with the rest zero. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle seconds pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (with bus_sel) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr, 0 when bus_sel is low |
| irq | output | 1 | Interrupt request |
| onsw_out | output | 1 | Power-on-switch output |

## Verification
The bench runs the counters across the 0xFFFFFFFF boundary while the match registers still hold their reset value. A design that ignored wrap, or gated the status latches with the interrupt enables, would show different status there. It issues a clear while the up-counter still equals the match value; a design that let the clear win would lose the latch. It writes counters both while running and while frozen, and it tries counter writes and ticks under soft reset. Misordered counter priorities would then move the time. A reference model runs in parallel with the design on every clock, so any drift in `irq` or `onsw_out` shows up in the cycle where it first happens.

// File: rtl/rtc_sec_pkg.sv
// Shared constants for the seconds counter: register offsets and control bits.
// Assumes byte offsets within a 32-byte window, one register per word.
package rtc_sec_pkg;
    localparam int NUM_MATCH = 2;

    localparam int OFS_UP  = 'h00;
    localparam int OFS_DN  = 'h04;
    localparam int OFS_M0  = 'h08;
    localparam int OFS_M1  = 'h0C;
    localparam int OFS_CTL = 'h10;
    localparam int OFS_IST = 'h14;
    localparam int OFS_KEY = 'h18;

    localparam int CB_IE0  = 0;
    localparam int CB_IE1  = 1;
    localparam int CB_OE0  = 2;
    localparam int CB_OE1  = 3;
    localparam int CB_SRST = 4;
    localparam int CB_FRZ  = 6;
    localparam int CB_FHI  = 7;

    localparam logic [7:0] CTL_MASK = 8'hDF;
    localparam int ST_W = NUM_MATCH + 1;
endpackage

// File: rtl/rtc_sec_regs.sv
// Configuration storage: control byte, match values and setup key.
// Assumes wr_en is a single-cycle write strobe already decoded from the bus.
module rtc_sec_regs
    import rtc_sec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [DATA_W-1:0]                     wdata,
    output logic [7:0]                            ctrl_q,
    output logic [NUM_MATCH-1:0][DATA_W-1:0]      match_q,
    output logic [DATA_W-1:0]                     key_q
);
    // Control and key register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            key_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(OFS_CTL)) ctrl_q <= wdata[7:0] & CTL_MASK;
            if (addr == ADDR_W'(OFS_KEY)) key_q  <= wdata;
        end
    end

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_match
        localparam int MOFS = OFS_M0 + 4 * k;
        // Match register k update; parks at all ones after reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                match_q[k] <= '1;
            else if (wr_en && addr == ADDR_W'(MOFS))
                match_q[k] <= wdata;
        end
    end

    // R11
    ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTL_MASK) == 8'h00);
endmodule

// File: rtl/rtc_sec_counters.sv
// Paired seconds counters: up-count and down-count, with freeze and soft reset.
// Assumes tick is one clock wide; soft reset takes priority over freeze.
module rtc_sec_counters #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              srst,
    input  logic              freeze,
    input  logic              wr_up,
    input  logic              wr_dn,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] up_q,
    output logic [DATA_W-1:0] dn_q
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Counter update: reset, soft reset, frozen load, or tick step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= '0;
            dn_q <= '1;
        end else if (srst) begin
            up_q <= '0;
            dn_q <= '0;
        end else if (freeze) begin
            if (wr_up) up_q <= wdata;
            if (wr_dn) dn_q <= wdata;
        end else if (tick) begin
            up_q <= up_q + ONE;
            dn_q <= dn_q - ONE;
        end
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !freeze && tick) |=> (up_q == $past(up_q) + ONE) && (dn_q == $past(dn_q) - ONE));
    // R5
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !freeze && !tick) |=> $stable(up_q) && $stable(dn_q));
    // R4
    frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && freeze && !wr_up) |=> $stable(up_q));
    // R10
    srst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (up_q == '0) && (dn_q == '0));
endmodule

// File: rtl/rtc_sec_status.sv
// Match comparators, sticky status latches, interrupt and on-switch outputs.
// Assumes clr_bits is valid only with clr_wr; a set in the same cycle beats a clear.
module rtc_sec_status
    import rtc_sec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             srst,
    input  logic [DATA_W-1:0]                up_q,
    input  logic [NUM_MATCH-1:0][DATA_W-1:0] match_q,
    input  logic [NUM_MATCH-1:0]             irq_en,
    input  logic [NUM_MATCH-1:0]             onsw_en,
    input  logic                             force_hi,
    input  logic                             clr_wr,
    input  logic [ST_W-1:0]                  clr_bits,
    output logic [ST_W-1:0]                  st_q,
    output logic                             irq,
    output logic                             onsw_out
);
    logic [NUM_MATCH-1:0] eq;
    logic                 onsw_hit;

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
        assign eq[k] = (up_q == match_q[k]);

        // Sticky latch for match k: set on equality, cleared by write-one.
        always_ff @(posedge clk) begin
            if (!rst_n || srst)
                st_q[k] <= 1'b0;
            else if (eq[k])
                st_q[k] <= 1'b1;
            else if (clr_wr && clr_bits[k])
                st_q[k] <= 1'b0;
        end

        // R6
        match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (eq[k] && !srst) |=> st_q[k]);
        // R7
        match_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!eq[k] && clr_wr && clr_bits[k]) |=> !st_q[k]);
    end

    assign onsw_hit = |(eq & onsw_en);

    // Sticky on-switch latch.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)
            st_q[NUM_MATCH] <= 1'b0;
        else if (onsw_hit)
            st_q[NUM_MATCH] <= 1'b1;
        else if (clr_wr && clr_bits[NUM_MATCH])
            st_q[NUM_MATCH] <= 1'b0;
    end

    // Output combination of latches and enables.
    always_comb begin
        irq      = |(st_q[NUM_MATCH-1:0] & irq_en);
        onsw_out = st_q[NUM_MATCH] | force_hi;
    end

    // R9
    onsw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[NUM_MATCH]) |-> $past(onsw_hit));
    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (st_q == '0));
endmodule

// File: rtl/rtc_sec_core.sv
// Top of the seconds counter: bus decode, read mux and wiring of the parts.
// Assumes a synchronous bus where a write is one cycle of bus_sel with bus_wr;
// reads are combinational and free of side effects. ADDR_W must be at least 5.
module rtc_sec_core
    import rtc_sec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              onsw_out
);
    logic                             wr_en;
    logic [7:0]                       ctrl_q;
    logic [NUM_MATCH-1:0][DATA_W-1:0] match_q;
    logic [DATA_W-1:0]                key_q;
    logic [DATA_W-1:0]                up_q;
    logic [DATA_W-1:0]                dn_q;
    logic [ST_W-1:0]                  st_q;

    assign wr_en = bus_sel && bus_wr;

    rtc_sec_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .match_q (match_q),
        .key_q   (key_q)
    );

    rtc_sec_counters #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .srst   (ctrl_q[CB_SRST]),
        .freeze (ctrl_q[CB_FRZ]),
        .wr_up  (wr_en && bus_addr == ADDR_W'(OFS_UP)),
        .wr_dn  (wr_en && bus_addr == ADDR_W'(OFS_DN)),
        .wdata  (bus_wdata),
        .up_q   (up_q),
        .dn_q   (dn_q)
    );

    rtc_sec_status #(.DATA_W(DATA_W)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (ctrl_q[CB_SRST]),
        .up_q     (up_q),
        .match_q  (match_q),
        .irq_en   ({ctrl_q[CB_IE1], ctrl_q[CB_IE0]}),
        .onsw_en  ({ctrl_q[CB_OE1], ctrl_q[CB_OE0]}),
        .force_hi (ctrl_q[CB_FHI]),
        .clr_wr   (wr_en && bus_addr == ADDR_W'(OFS_IST)),
        .clr_bits (bus_wdata[ST_W-1:0]),
        .st_q     (st_q),
        .irq      (irq),
        .onsw_out (onsw_out)
    );

    // Read data selection by offset.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                ADDR_W'(OFS_UP):  bus_rdata = up_q;
                ADDR_W'(OFS_DN):  bus_rdata = dn_q;
                ADDR_W'(OFS_M0):  bus_rdata = match_q[0];
                ADDR_W'(OFS_M1):  bus_rdata = match_q[1];
                ADDR_W'(OFS_CTL): bus_rdata = {{(DATA_W-8){1'b0}}, ctrl_q};
                ADDR_W'(OFS_IST): bus_rdata = {{(DATA_W-ST_W){1'b0}}, st_q};
                ADDR_W'(OFS_KEY): bus_rdata = key_q;
                default:          bus_rdata = '0;
            endcase
        end
    end

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q[1:0] != 2'b00));
    // R1
    rst_val_chk: assert property (@(posedge clk)
        !rst_n |=> (up_q == '0) && (dn_q == '1) && (ctrl_q == 8'h00) && !irq);
endmodule

// File: tb/test_rtc_sec_core.sv
module test_rtc_sec_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        onsw_out;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    rtc_sec_core i_rtc_sec_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .onsw_out(onsw_out)
    );

    // Behavioural reference state.
    logic [31:0] m_up, m_dn, m_m0, m_m1, m_key;
    logic [7:0]  m_ctl;
    logic [2:0]  m_st;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [4:0] a);
        case (a)
            5'h00: return m_up;
            5'h04: return m_dn;
            5'h08: return m_m0;
            5'h0C: return m_m1;
            5'h10: return {24'h0, m_ctl};
            5'h14: return {29'h0, m_st};
            5'h18: return m_key;
            default: return 32'h0;
        endcase
    endfunction

    // Reference model: next state from the inputs present at this edge.
    always @(posedge clk) begin
        logic we, e0, e1;
        logic [2:0] clr;
        if (!rst_n) begin
            m_up = 0; m_dn = 32'hFFFF_FFFF; m_m0 = 32'hFFFF_FFFF; m_m1 = 32'hFFFF_FFFF;
            m_ctl = 0; m_st = 0; m_key = 0;
        end else begin
            we  = bus_sel && bus_wr;
            e0  = (m_up == m_m0);
            e1  = (m_up == m_m1);
            clr = (we && bus_addr == 5'h14) ? bus_wdata[2:0] : 3'b000;
            if (m_ctl[4]) begin
                m_st = 0; m_up = 0; m_dn = 0;
            end else begin
                m_st[0] = e0 ? 1'b1 : (m_st[0] & ~clr[0]);
                m_st[1] = e1 ? 1'b1 : (m_st[1] & ~clr[1]);
                m_st[2] = ((e0 && m_ctl[2]) || (e1 && m_ctl[3])) ? 1'b1 : (m_st[2] & ~clr[2]);
                if (m_ctl[6]) begin
                    if (we && bus_addr == 5'h00) m_up = bus_wdata;
                    if (we && bus_addr == 5'h04) m_dn = bus_wdata;
                end else if (tick) begin
                    m_up = m_up + 1;
                    m_dn = m_dn - 1;
                end
            end
            if (we && bus_addr == 5'h10) m_ctl = bus_wdata[7:0] & 8'hDF;
            if (we && bus_addr == 5'h08) m_m0 = bus_wdata;
            if (we && bus_addr == 5'h0C) m_m1 = bus_wdata;
            if (we && bus_addr == 5'h18) m_key = bus_wdata;
        end
    end

    // Per-cycle comparison of the outputs against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 irq", {31'h0, irq}, {31'h0, (m_st[0] & m_ctl[0]) | (m_st[1] & m_ctl[1])});
            chk("R9 onsw_out", {31'h0, onsw_out}, {31'h0, m_st[2] | m_ctl[7]});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        chk({req, " model"}, bus_rdata, mread(a));
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1;
            @(negedge clk);
            tick = 0;
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(5'h00, 32'h0, "R1 up");
        rd(5'h04, 32'hFFFF_FFFF, "R1 down");
        rd(5'h08, 32'hFFFF_FFFF, "R1 match0");
        rd(5'h0C, 32'hFFFF_FFFF, "R1 match1");
        rd(5'h10, 32'h0, "R1 ctrl");
        rd(5'h14, 32'h0, "R1 status");
        rd(5'h18, 32'h0, "R1 key");
        chk("R1 irq", {31'h0, irq}, 32'h0);
        // R2 counting
        ticks(5);
        rd(5'h00, 32'h5, "R2 up");
        rd(5'h04, 32'hFFFF_FFFA, "R2 down");
        // R5 write while running
        wr(5'h00, 32'h1234);
        wr(5'h04, 32'h1234);
        rd(5'h00, 32'h5, "R5 up");
        rd(5'h04, 32'hFFFF_FFFA, "R5 down");
        // R4 freeze and load
        wr(5'h10, 32'h40);
        ticks(3);
        rd(5'h00, 32'h5, "R4 ticks ignored");
        wr(5'h00, 32'hFFFF_FFFE);
        wr(5'h04, 32'h1);
        rd(5'h00, 32'hFFFF_FFFE, "R4 up load");
        rd(5'h04, 32'h1, "R4 down load");
        // R3 wrap; passing 0xFFFFFFFF also hits both parked match values (R6)
        wr(5'h10, 32'h0);
        ticks(3);
        rd(5'h00, 32'h1, "R3 up wrap");
        rd(5'h04, 32'hFFFF_FFFE, "R3 down wrap");
        rd(5'h14, 32'h3, "R6 latch without enable");
        chk("R8 irq disabled", {31'h0, irq}, 32'h0);
        wr(5'h14, 32'h3);
        rd(5'h14, 32'h0, "R7 clear");
        // R6/R7/R8 match sequence
        wr(5'h10, 32'h40);
        wr(5'h00, 32'h10);
        wr(5'h04, 32'hFFFF_FFEF);
        wr(5'h08, 32'h12);
        wr(5'h0C, 32'h20);
        wr(5'h10, 32'h0B);
        ticks(2);
        @(negedge clk);
        rd(5'h14, 32'h1, "R6 match0 set");
        chk("R8 irq on match0", {31'h0, irq}, 32'h1);
        wr(5'h14, 32'h1);
        rd(5'h14, 32'h1, "R6 clear loses while equal");
        ticks(1);
        wr(5'h14, 32'h0);
        rd(5'h14, 32'h1, "R7 zero write keeps");
        wr(5'h14, 32'h1);
        rd(5'h14, 32'h0, "R7 one write clears");
        chk("R8 irq dropped", {31'h0, irq}, 32'h0);
        ticks(13);
        @(negedge clk);
        rd(5'h14, 32'h6, "R9 match1 with onsw");
        chk("R9 onsw high", {31'h0, onsw_out}, 32'h1);
        chk("R8 irq on match1", {31'h0, irq}, 32'h1);
        ticks(1);
        wr(5'h14, 32'h4);
        rd(5'h14, 32'h2, "R9 onsw latch cleared");
        chk("R9 onsw low", {31'h0, onsw_out}, 32'h0);
        wr(5'h10, 32'h8B);
        chk("R9 force high", {31'h0, onsw_out}, 32'h1);
        // R10 soft reset
        wr(5'h10, 32'h9B);
        ticks(2);
        wr(5'h00, 32'h55);
        rd(5'h00, 32'h0, "R10 up held");
        rd(5'h04, 32'h0, "R10 down held");
        rd(5'h14, 32'h0, "R10 status cleared");
        rd(5'h08, 32'h12, "R10 match kept");
        rd(5'h10, 32'h9B, "R10 ctrl kept");
        wr(5'h10, 32'h0B);
        ticks(1);
        rd(5'h00, 32'h1, "R10 release counts");
        // R11 key, ctrl mask, unmapped
        wr(5'h18, 32'hB5C1_3F27);
        rd(5'h18, 32'hB5C1_3F27, "R11 key");
        wr(5'h10, 32'hFFFF_FF20);
        rd(5'h10, 32'h0, "R11 ctrl bit5 dropped");
        wr(5'h10, 32'h0000_00EF);
        rd(5'h10, 32'hCF, "R11 ctrl mask");
        rd(5'h1C, 32'h0, "R11 unmapped");
        wr(5'h10, 32'h0);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule